// File: doc/BRIEF.md
# Oscillator Gate and Rate-Select Divider

This block sits between a 32.768 kHz clock-enable strobe and the timekeeping and interrupt logic of a real-time clock. A three-bit control field decides whether the oscillator counts as powered. It also decides whether the 15-stage binary divider counts or is held at its restart point. Each enabled strobe advances the divider by one, so stage k toggles at 32768 / 2^(k+1) Hz. Stage 14 wraps once per second and raises a one-cycle seconds tick for the update logic.

A four-bit rate code picks one divider stage through a single selector. That one choice drives two outputs. The first is a square wave, which can be forced low by its own enable. The second is a one-cycle periodic strobe on each rising edge of the chosen stage, which has its own enable. All pins are plain control and status levels. Nothing flows as a stream, so there is no handshake at the edge of the block.

Top module: `osc_rate_divider`

## Requirements
- R1: `osc_on` is high one cycle after `osc_ctl` holds 3'b010, 3'b110 or 3'b111, and low one cycle after any other value.
- R2: The divider advances only while `osc_ctl` is 3'b010. In every off pattern (000, 001, 011, 100, 101) it keeps its phase. While off, `sqw_out` holds its level and no `periodic_evt` or `sec_tick` occurs. Returning to 3'b010 resumes counting.
- R3: While `osc_ctl[2:1]` is 2'b11, the divider is held at its midpoint (stage 14 set, all lower stages clear). During the hold, `sec_tick`, `periodic_evt` and `sqw_out` stay low. After a change to 3'b010, the first `sec_tick` appears 16384 enabled strobes later, and later ones every 32768.
- R4: Rate code mapping to divider stage (stage k runs at 32768/2^(k+1) Hz): 0001→stage 6 (256 Hz), 0010→stage 7 (128 Hz), 0011→stage 1 (8192 Hz), and codes 0100 to 1111 map to stages 2 to 13 (4096 Hz down to 2 Hz). After release from hold, with a strobe every cycle, the first `periodic_evt` comes 2^k+1 cycles after the release.
- R5: Rate code 0000 selects nothing. `sqw_out` and `periodic_evt` stay low.
- R6: With `sqw_en` low, `sqw_out` is low. With it high, `sqw_out` follows the selected stage one cycle later, at 50 % duty.
- R7: `periodic_evt` is a one-cycle strobe, one per rising edge of the selected stage, and appears only when `pie_en` is high.
- R8: With `osc_tick` low, the divider does not advance, so no strobes or ticks appear and `sqw_out` holds its level.
- R9: During reset, `osc_on`, `sqw_out`, `periodic_evt` and `sec_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | 32.768 kHz clock-enable strobe |
| osc_ctl | input | 3 | Oscillator/divider control pattern |
| rate_sel | input | 4 | Rate code for the shared stage selector |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic strobe enable |
| osc_on | output | 1 | Oscillator powered indication |
| sqw_out | output | 1 | Gated square wave |
| periodic_evt | output | 1 | One-cycle periodic strobe |
| sec_tick | output | 1 | One-cycle seconds tick |

## Verification
A wrong divider phase shows up as a first periodic strobe or first seconds tick on the wrong cycle after release from hold. The error is visible within 2^k+1 cycles for the fast rates and at cycle 16384 for the seconds tick. A wrong code-to-stage mapping or a dead stage changes the strobe count and the square-wave high count within a few periods of the selected stage. A divider that advances while off or held shows as strobes or a moving square wave during those windows, within one period of the chosen stage.

// File: rtl/osc_div_pkg.sv
`timescale 1ns/1ps
package osc_div_pkg;

  localparam int unsigned DIV_STAGES = 15;
  localparam int unsigned CTL_W      = 3;
  localparam int unsigned RS_W       = 4;

  typedef enum logic [1:0] {
    OSC_OFF  = 2'd0,
    OSC_RUN  = 2'd1,
    OSC_HOLD = 2'd2
  } osc_mode_e;

  // Divider stage chosen by a nonzero rate code.
  function automatic int unsigned rate_tap(input int unsigned code);
    if (code == 1)      return 6;
    else if (code == 2) return 7;
    else                return code - 2;
  endfunction

endpackage

// File: rtl/osc_gate.sv
`timescale 1ns/1ps
module osc_gate
  import osc_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [CTL_W-1:0] ctl,
  output osc_mode_e        mode,
  output logic             advance,
  output logic             hold,
  output logic             osc_on
);

  always_comb begin
    if (ctl[2:1] == 2'b11)     mode = OSC_HOLD;
    else if (ctl == 3'b010)    mode = OSC_RUN;
    else                       mode = OSC_OFF;
  end

  assign advance = (mode == OSC_RUN) && osc_tick;
  assign hold    = (mode == OSC_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) osc_on <= 1'b0;
    else        osc_on <= (mode != OSC_OFF);
  end

endmodule

// File: rtl/div_chain.sv
`timescale 1ns/1ps
module div_chain #(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              hold,
  output logic [STAGES-1:0] taps,
  output logic              wrap
);

  logic [STAGES:0] carry;

  assign carry[0] = advance;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam logic PRESET = (i == STAGES - 1) ? 1'b1 : 1'b0;
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (hold)     q <= PRESET;
      else if (carry[i]) q <= ~q;
    end
    assign taps[i]    = q;
    assign carry[i+1] = carry[i] & q;
  end

  assign wrap = carry[STAGES];

endmodule

// File: rtl/tap_select.sv
`timescale 1ns/1ps
module tap_select
  import osc_div_pkg::*;
#(
  parameter int unsigned STAGES = 15,
  parameter int unsigned SEL_W  = 4
) (
  input  logic [STAGES-1:0] taps,
  input  logic [SEL_W-1:0]  rate_sel,
  output logic              sel_tap
);

  localparam int unsigned NCODES = 1 << SEL_W;

  logic [NCODES-1:0] hit;

  assign hit[0] = 1'b0;

  for (genvar c = 1; c < NCODES; c++) begin : g_code
    localparam int unsigned TAP = rate_tap(c);
    assign hit[c] = (rate_sel == SEL_W'(c)) & taps[TAP];
  end

  assign sel_tap = |hit;

endmodule

// File: rtl/pulse_out.sv
`timescale 1ns/1ps
module pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_tap,
  input  logic wrap,
  input  logic sqw_en,
  input  logic pie_en,
  output logic sqw_out,
  output logic periodic_evt,
  output logic sec_tick
);

  logic tap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q        <= 1'b0;
      sqw_out      <= 1'b0;
      periodic_evt <= 1'b0;
      sec_tick     <= 1'b0;
    end else begin
      tap_q        <= sel_tap;
      sqw_out      <= sqw_en & sel_tap;
      periodic_evt <= pie_en & sel_tap & ~tap_q;
      sec_tick     <= wrap;
    end
  end

endmodule

// File: rtl/osc_rate_divider.sv
`timescale 1ns/1ps
module osc_rate_divider
  import osc_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [CTL_W-1:0] osc_ctl,
  input  logic [RS_W-1:0]  rate_sel,
  input  logic             sqw_en,
  input  logic             pie_en,
  output logic             osc_on,
  output logic             sqw_out,
  output logic             periodic_evt,
  output logic             sec_tick
);

  osc_mode_e             mode;
  logic                  advance;
  logic                  hold;
  logic [DIV_STAGES-1:0] taps;
  logic                  wrap;
  logic                  sel_tap;

  osc_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .ctl      (osc_ctl),
    .mode     (mode),
    .advance  (advance),
    .hold     (hold),
    .osc_on   (osc_on)
  );

  div_chain #(.STAGES(DIV_STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .hold    (hold),
    .taps    (taps),
    .wrap    (wrap)
  );

  tap_select #(.STAGES(DIV_STAGES), .SEL_W(RS_W)) u_sel (
    .taps     (taps),
    .rate_sel (rate_sel),
    .sel_tap  (sel_tap)
  );

  pulse_out u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_tap      (sel_tap),
    .wrap         (wrap),
    .sqw_en       (sqw_en),
    .pie_en       (pie_en),
    .sqw_out      (sqw_out),
    .periodic_evt (periodic_evt),
    .sec_tick     (sec_tick)
  );

endmodule

// File: rtl/osc_rate_divider_chk.sv
`timescale 1ns/1ps
module osc_rate_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic [2:0] osc_ctl,
  input logic [3:0] rate_sel,
  input logic       sqw_en,
  input logic       pie_en,
  input logic       osc_on,
  input logic       sqw_out,
  input logic       periodic_evt,
  input logic       sec_tick
);

  AST_OSC_ON_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_on |-> $past(osc_ctl == 3'b010 || osc_ctl[2:1] == 2'b11)); // R1

  AST_SEC_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_ctl == 3'b010 && osc_tick)); // R2

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(osc_ctl[2:1] == 2'b11) && $past(osc_ctl[2:1] == 2'b11, 2))
      |-> (!sec_tick && !periodic_evt && !sqw_out)); // R3

  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rate_sel == 4'd0) |-> (!sqw_out && !periodic_evt)); // R5

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_out |-> $past(sqw_en)); // R6

  AST_PI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |-> $past(pie_en)); // R7

  AST_PI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |=> !periodic_evt); // R7

endmodule

bind osc_rate_divider osc_rate_divider_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .osc_tick     (osc_tick),
  .osc_ctl      (osc_ctl),
  .rate_sel     (rate_sel),
  .sqw_en       (sqw_en),
  .pie_en       (pie_en),
  .osc_on       (osc_on),
  .sqw_out      (sqw_out),
  .periodic_evt (periodic_evt),
  .sec_tick     (sec_tick)
);

// File: tb/test_osc_rate_divider.sv
`timescale 1ns/1ps
module test_osc_rate_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] osc_ctl = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       pie_en = 1'b0;
  logic       osc_on, sqw_out, periodic_evt, sec_tick;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  osc_rate_divider i_osc_rate_divider (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_tick     (osc_tick),
    .osc_ctl      (osc_ctl),
    .rate_sel     (rate_sel),
    .sqw_en       (sqw_en),
    .pie_en       (pie_en),
    .osc_on       (osc_on),
    .sqw_out      (sqw_out),
    .periodic_evt (periodic_evt),
    .sec_tick     (sec_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold_release(input logic [2:0] pat);
    osc_ctl = pat;
    repeat (4) @(negedge clk);
    osc_ctl = 3'b010;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 osc_on", osc_on, 0);
    chk("R9 sqw_out", sqw_out, 0);
    chk("R9 periodic_evt", periodic_evt, 0);
    chk("R9 sec_tick", sec_tick, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_decode;
    for (int c = 0; c < 8; c++) begin
      osc_ctl = 3'(c);
      @(negedge clk);
      chk("R1 decode", osc_on, (c == 2 || c >= 6) ? 1 : 0);
    end
  endtask

  task automatic t_rate(input logic [3:0] code, input int b);
    int first, evts, highs, w, per;
    rate_sel = code; pie_en = 1'b1; sqw_en = 1'b1; osc_tick = 1'b1;
    hold_release(3'b110);
    first = -1;
    for (int i = 1; i <= (1 << b) + 8; i++) begin
      @(negedge clk);
      if (periodic_evt) begin first = i; break; end
    end
    chk("R4 first strobe", first, (1 << b) + 1);
    per = 1 << (b + 1);
    w = ((b > 10) ? 1 : 4) * per;
    evts = 0; highs = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      evts += int'(periodic_evt);
      highs += int'(sqw_out);
    end
    chk("R7 strobe count", evts, w / per);
    chk("R6 sqw duty", highs, w / 2);
  endtask

  task automatic t_rate0;
    int evts, highs;
    rate_sel = 4'd0; pie_en = 1'b1; sqw_en = 1'b1; osc_tick = 1'b1;
    osc_ctl = 3'b010;
    evts = 0; highs = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      evts += int'(periodic_evt);
      highs += int'(sqw_out);
    end
    chk("R5 no strobe", evts, 0);
    chk("R5 sqw low", highs, 0);
  endtask

  task automatic t_gates;
    int evts, highs;
    rate_sel = 4'b0100; pie_en = 1'b0; sqw_en = 1'b0; osc_tick = 1'b1;
    osc_ctl = 3'b010;
    @(negedge clk);
    evts = 0; highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      evts += int'(periodic_evt);
      highs += int'(sqw_out);
    end
    chk("R7 pie_en low", evts, 0);
    chk("R6 sqw_en low", highs, 0);
    sqw_en = 1'b1;
    @(negedge clk);
    highs = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      highs += int'(sqw_out);
    end
    chk("R6 sqw_en high", highs, 32);
  endtask

  task automatic t_off;
    int evts, flips;
    logic s;
    rate_sel = 4'b0011; pie_en = 1'b1; sqw_en = 1'b1; osc_tick = 1'b1;
    hold_release(3'b110);
    repeat (10) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      osc_ctl = (p == 0) ? 3'b000 : 3'b101;
      repeat (2) @(negedge clk);
      chk("R1 off pattern", osc_on, 0);
      s = sqw_out; evts = 0; flips = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        evts += int'(periodic_evt);
        flips += int'(sqw_out != s);
      end
      chk("R2 off no strobe", evts, 0);
      chk("R2 off sqw frozen", flips, 0);
    end
    osc_ctl = 3'b010;
    @(negedge clk);
    evts = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      evts += int'(periodic_evt);
    end
    chk("R2 resume", evts, 4);
  endtask

  task automatic t_tick_gate;
    int evts, flips;
    logic s;
    rate_sel = 4'b0011; pie_en = 1'b1; sqw_en = 1'b1;
    osc_ctl = 3'b010; osc_tick = 1'b0;
    repeat (2) @(negedge clk);
    s = sqw_out; evts = 0; flips = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      evts += int'(periodic_evt);
      flips += int'(sqw_out != s);
    end
    chk("R8 no strobe", evts, 0);
    chk("R8 sqw frozen", flips, 0);
    osc_tick = 1'b1;
  endtask

  task automatic t_hold_quiet;
    int busy;
    rate_sel = 4'b0011; pie_en = 1'b1; sqw_en = 1'b1; osc_tick = 1'b1;
    osc_ctl = 3'b111;
    repeat (2) @(negedge clk);
    busy = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      busy += int'(periodic_evt | sqw_out | sec_tick);
    end
    chk("R3 hold quiet", busy, 0);
    chk("R1 hold osc_on", osc_on, 1);
  endtask

  task automatic t_seconds;
    int first, next;
    rate_sel = 4'd0; osc_tick = 1'b1;
    hold_release(3'b111);
    first = -1;
    for (int i = 1; i <= 16400; i++) begin
      @(negedge clk);
      if (sec_tick) begin first = i; break; end
    end
    chk("R3 first second", first, 16384);
    next = -1;
    for (int i = 1; i <= 32800; i++) begin
      @(negedge clk);
      if (sec_tick) begin next = i; break; end
    end
    chk("R3 second period", next, 32768);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_decode();
    t_rate(4'b0011, 1);
    t_rate(4'b0100, 2);
    t_rate(4'b0001, 6);
    t_rate(4'b0010, 7);
    t_rate(4'b1010, 8);
    t_rate(4'b1111, 13);
    t_rate0();
    t_gates();
    t_off();
    t_tick_gate();
    t_hold_quiet();
    t_seconds();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule